// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Decoder

This block takes a data word that was stored or transported together with its check bits and checks the two against each other. It works out the check bits again from the data it receives and compares them with the check bits it was given. The result is a Hamming syndrome plus one overall-parity mismatch bit. Together these decide the outcome. The decoder then returns the data, with one bit corrected where that is possible. It also raises one of two flags: one for an error that was fixed, one for an error that cannot be fixed.

The decoder is purely combinational, so it can sit directly in a read path. Two parameters must match the encoder that produced the word: the data width and the parity polarity (even or odd). Check bits that have no error in them never change the data output. Only an error that lands on a data bit flips an output bit.

Top module: `secded_decoder`

## Requirements
- R1: The check vector has ECC_W = clog2(DATA_W)+2 bits. Codeword positions are numbered from 1.
    - For k below ECC_W-1, `ecc[k]` is a Hamming bit at position 2^k.
    - Data bit i sits at the i-th non-power-of-two position in ascending order, so data bit 0 is at position 3.
    - `ecc[ECC_W-1]` is the overall parity bit.
    - With ODD_PAR=0, each Hamming bit k is the XOR of the data bits whose position has bit k set. The overall bit is chosen so that the XOR of all data and check bits is 0.
    - With ODD_PAR=1, each Hamming bit is that XOR inverted. The overall bit is chosen so that the XOR of the whole codeword is 1.
- R2: For an error-free codeword, sec=0, ded=0 and data_out equals data.
- R3: A single flipped data bit gives sec=1 and ded=0, and data_out is the originally encoded data.
- R4: A single flipped Hamming bit gives sec=1 and ded=0, and data_out equals the data input.
- R5: A single flipped overall parity bit (zero syndrome with a parity mismatch) gives sec=1 and ded=0, and data_out equals the data input.
- R6: Any two flipped codeword bits give sec=0 and ded=1, and data_out equals the data input unchanged.
- R7: A parity mismatch whose syndrome points above the last codeword position (DATA_W+ECC_W-1) is uncorrectable: ded=1 and sec=0, with data passed through unchanged.
- R8: sec and ded are never 1 at the same time.
- R9: With ODD_PAR=1, the decoder behaves as in R2 to R7 on codewords built with the odd rule of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data | input | DATA_W | Received data word |
| ecc | input | ECC_W | Received check bits: Hamming bits low, overall parity bit at the MSB |
| data_out | output | DATA_W | Corrected data |
| sec | output | 1 | A single error was found and handled |
| ded | output | 1 | An uncorrectable error was found |

## Verification
A wrong syndrome or position map shows up at once, in the same evaluation as the input. Either the wrong data bit flips, or a bit flips when only a check bit was hit. The bench catches both by comparing data_out with the originally encoded word. A wrong classification shows as a wrong flag, or as sec and ded both high. A wrong polarity shows as a spurious error flag on a clean odd-parity word. Both instances are driven with random clean, single-error and double-error codewords, plus fixed corner cases: the overall bit, the highest data position, and a syndrome outside the codeword.

// File: rtl/secded_pkg.sv
package secded_pkg;

    typedef enum logic [2:0] {
        VD_CLEAN   = 3'd0,
        VD_DATA    = 3'd1,
        VD_CHECK   = 3'd2,
        VD_OVERALL = 3'd3,
        VD_BAD     = 3'd4
    } verdict_e;

    // Number of Hamming (non-overall) check bits for a data width.
    function automatic int unsigned ham_bits(int unsigned dw);
        return $clog2(dw) + 1;
    endfunction

    // Codeword position (1-based) of data bit idx: skip every power of two.
    function automatic int unsigned data_pos(int unsigned idx);
        int unsigned p;
        p = idx + 1;
        for (int b = 0; b < 31; b++) begin
            if ((32'd1 << b) <= p) p = p + 1;
        end
        return p;
    endfunction

    function automatic logic is_pow2(int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/secded_chkgen.sv
module secded_chkgen
    import secded_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned HAM_W   = 6,
    parameter bit          ODD_PAR = 1'b0
) (
    input  logic [DATA_W-1:0] data,
    output logic [HAM_W-1:0]  chk
);
    for (genvar k = 0; k < HAM_W; k++) begin : g_chk
        always_comb begin
            logic acc;
            acc = ODD_PAR;
            for (int unsigned i = 0; i < DATA_W; i++) begin
                if (((data_pos(i) >> k) & 32'd1) != 0) acc = acc ^ data[i];
            end
            chk[k] = acc;
        end
    end
endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned HAM_W   = 6,
    parameter bit          ODD_PAR = 1'b0
) (
    input  logic [DATA_W-1:0] data,
    input  logic [HAM_W:0]    ecc_rx,
    input  logic [HAM_W-1:0]  chk_calc,
    output logic [HAM_W-1:0]  syn,
    output logic              par_err
);
    always_comb begin
        syn     = ecc_rx[HAM_W-1:0] ^ chk_calc;
        par_err = (^data) ^ (^ecc_rx) ^ ODD_PAR;
    end
endmodule

// File: rtl/secded_classify.sv
module secded_classify
    import secded_pkg::*;
#(
    parameter int unsigned HAM_W  = 6,
    parameter int unsigned CW_LEN = 38
) (
    input  logic [HAM_W-1:0] syn,
    input  logic             par_err,
    output verdict_e         verdict,
    output logic             flip_en,
    output logic             sec,
    output logic             ded
);
    always_comb begin
        if (syn == '0) begin
            verdict = par_err ? VD_OVERALL : VD_CLEAN;
        end else if (!par_err) begin
            verdict = VD_BAD;                       // even count of flips
        end else if (32'(syn) > CW_LEN) begin
            verdict = VD_BAD;                       // points outside codeword
        end else if (is_pow2(32'(syn))) begin
            verdict = VD_CHECK;
        end else begin
            verdict = VD_DATA;
        end
        flip_en = (verdict == VD_DATA);
        sec     = (verdict == VD_DATA) || (verdict == VD_CHECK) ||
                  (verdict == VD_OVERALL);
        ded     = (verdict == VD_BAD);
    end

    always_comb begin
        if (!$isunknown({syn, par_err})) begin
            // R8: the two status flags exclude each other
            a_r8_flags_exclusive: assert (!(sec && ded))
                else $error("sec and ded both set");
            // R6: an even number of flips never asks for a correction
            a_r6_no_fix_on_even: assert (par_err || !flip_en)
                else $error("flip requested without parity mismatch");
        end
    end
endmodule

// File: rtl/secded_fix.sv
module secded_fix
    import secded_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned HAM_W  = 6
) (
    input  logic [DATA_W-1:0] data,
    input  logic [HAM_W-1:0]  syn,
    input  logic              flip_en,
    output logic [DATA_W-1:0] data_out
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam int unsigned POS = data_pos(i);
        assign data_out[i] = data[i] ^ (flip_en && (32'(syn) == POS));
    end

    always_comb begin
        if (!$isunknown({data, syn, flip_en})) begin
            // R3: correction touches at most one bit
            a_r3_single_flip: assert ($countones(data_out ^ data) <= 1)
                else $error("more than one data bit changed");
        end
    end
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
    import secded_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter bit          ODD_PAR = 1'b0,
    localparam int unsigned HAM_W  = ham_bits(DATA_W),
    localparam int unsigned ECC_W  = HAM_W + 1
) (
    input  logic [DATA_W-1:0] data,
    input  logic [ECC_W-1:0]  ecc,
    output logic [DATA_W-1:0] data_out,
    output logic              sec,
    output logic              ded
);
    localparam int unsigned CW_LEN = DATA_W + HAM_W;

    logic [HAM_W-1:0] chk_calc;
    logic [HAM_W-1:0] syn;
    logic             par_err;
    logic             flip_en;
    verdict_e         verdict;

    secded_chkgen #(.DATA_W(DATA_W), .HAM_W(HAM_W), .ODD_PAR(ODD_PAR)) u_chkgen (
        .data (data),
        .chk  (chk_calc)
    );

    secded_syndrome #(.DATA_W(DATA_W), .HAM_W(HAM_W), .ODD_PAR(ODD_PAR)) u_syn (
        .data     (data),
        .ecc_rx   (ecc),
        .chk_calc (chk_calc),
        .syn      (syn),
        .par_err  (par_err)
    );

    secded_classify #(.HAM_W(HAM_W), .CW_LEN(CW_LEN)) u_cls (
        .syn     (syn),
        .par_err (par_err),
        .verdict (verdict),
        .flip_en (flip_en),
        .sec     (sec),
        .ded     (ded)
    );

    secded_fix #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_fix (
        .data     (data),
        .syn      (syn),
        .flip_en  (flip_en),
        .data_out (data_out)
    );

    always_comb begin
        if (!$isunknown({data, ecc})) begin
            // R2: no flag means the data is passed untouched
            a_r2_clean_passthru: assert (sec || ded || (data_out == data))
                else $error("data changed without a flag");
            // R6 / R7: uncorrectable words are never altered
            a_r7_bad_untouched: assert (!ded || (data_out == data))
                else $error("data changed on uncorrectable word");
            // R5: overall-bit hit leaves data alone
            a_r5_overall_hit: assert (!((syn == '0) && par_err) || (sec && (data_out == data)))
                else $error("overall parity hit mishandled");
        end
    end
endmodule

// File: tb/secded_decoder_test.sv
module secded_decoder_test;
    localparam int CLK_P = 10;
    localparam int DW    = 32;
    localparam int HW    = 6;
    localparam int EW    = HW + 1;
    localparam int NPOS  = DW + HW;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic [DW-1:0] d_ev, d_od, q_ev, q_od;
    logic [EW-1:0] e_ev, e_od;
    logic          s_ev, s_od, x_ev, x_od;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    secded_decoder #(.DATA_W(DW), .ODD_PAR(1'b0)) uut (
        .data(d_ev), .ecc(e_ev), .data_out(q_ev), .sec(s_ev), .ded(x_ev));
    secded_decoder #(.DATA_W(DW), .ODD_PAR(1'b1)) uut_odd (
        .data(d_od), .ecc(e_od), .data_out(q_od), .sec(s_od), .ded(x_od));

    function automatic bit tb_pow2(int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    function automatic logic [EW-1:0] tb_encode(logic [DW-1:0] d, bit odd);
        logic [63:0]   cw;
        logic [EW-1:0] e;
        int di;
        cw = '0;
        di = 0;
        for (int p = 1; p <= NPOS; p++) begin
            if (!tb_pow2(p)) begin
                cw[p] = d[di];
                di++;
            end
        end
        for (int k = 0; k < HW; k++) begin
            logic a;
            a = odd;
            for (int p = 1; p <= NPOS; p++) if (p[k]) a = a ^ cw[p];
            e[k] = a;
        end
        e[EW-1] = odd ^ (^d) ^ (^e[HW-1:0]);
        return e;
    endfunction

    // Flip one codeword position in the packed {ecc, data} word; 0 = overall bit.
    function automatic logic [EW+DW-1:0] tb_flip(logic [EW+DW-1:0] w, int pos);
        int cnt;
        if (pos == 0) begin
            w[DW+EW-1] = ~w[DW+EW-1];
        end else if (tb_pow2(pos)) begin
            for (int k = 0; k < HW; k++) if ((1 << k) == pos) w[DW+k] = ~w[DW+k];
        end else begin
            cnt = 0;
            for (int p = 1; p < pos; p++) if (!tb_pow2(p)) cnt++;
            w[cnt] = ~w[cnt];
        end
        return w;
    endfunction

    task automatic apply(bit odd, logic [DW-1:0] d, logic [EW-1:0] e,
                         bit xs, bit xd, logic [DW-1:0] xq, string req);
        logic [DW-1:0] q;
        logic s, x;
        @(posedge clk);
        #1;
        if (odd) begin d_od = d; e_od = e; end
        else     begin d_ev = d; e_ev = e; end
        @(negedge clk);
        q = odd ? q_od : q_ev;
        s = odd ? s_od : s_ev;
        x = odd ? x_od : x_ev;
        n_chk++;
        if (q !== xq || s !== xs || x !== xd) begin
            n_fail++;
            $display("FAIL %s odd=%0d: got data=%h sec=%b ded=%b, expected data=%h sec=%b ded=%b",
                     req, odd, q, s, x, xq, xs, xd);
        end
    endtask

    initial begin
        logic [DW-1:0]    d;
        logic [EW-1:0]    e;
        logic [EW+DW-1:0] w;
        int a, b;
        d_ev = '0; e_ev = '0; d_od = '0; e_od = '0;
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);

        // R2: all-zero word, even and odd (R9)
        apply(1'b0, '0, tb_encode('0, 1'b0), 1'b0, 1'b0, '0, "R2 zero word");
        apply(1'b1, '0, tb_encode('0, 1'b1), 1'b0, 1'b0, '0, "R9 zero word odd");
        // R1: encoding layout for all-ones and a single data bit
        apply(1'b0, '1, tb_encode('1, 1'b0), 1'b0, 1'b0, '1, "R1 all ones");
        apply(1'b1, 32'h1, tb_encode(32'h1, 1'b1), 1'b0, 1'b0, 32'h1, "R1 bit0 odd");
        // R5: overall bit hit
        d = 32'hA5A5_0F0F;
        e = tb_encode(d, 1'b0);
        apply(1'b0, d, e ^ 7'b100_0000, 1'b1, 1'b0, d, "R5 overall bit");
        // R4: Hamming bit at position 16
        apply(1'b0, d, e ^ 7'b001_0000, 1'b1, 1'b0, d, "R4 check bit");
        // R3: highest data position (38 -> data bit 31)
        apply(1'b0, d ^ 32'h8000_0000, e, 1'b1, 1'b0, d, "R3 top data bit");
        // R7: syndrome 8^16^32=56 beyond position 38, with parity mismatch
        apply(1'b0, d, e ^ 7'b011_1000, 1'b0, 1'b1, d, "R7 out of range");
        apply(1'b1, d, tb_encode(d, 1'b1) ^ 7'b011_1000, 1'b0, 1'b1, d, "R7 out of range odd");
        // R6: data bit plus overall bit
        apply(1'b0, d ^ 32'h1, e ^ 7'b100_0000, 1'b0, 1'b1, d ^ 32'h1, "R6 data+overall");

        for (int it = 0; it < 400; it++) begin
            bit odd;
            int kind;
            odd  = it[0];
            kind = int'($urandom_range(2, 0));
            d = $urandom;
            e = tb_encode(d, odd);
            w = {e, d};
            if (kind == 0) begin
                apply(odd, d, e, 1'b0, 1'b0, d, odd ? "R9 random clean" : "R2 random clean");
            end else if (kind == 1) begin
                a = int'($urandom_range(NPOS, 0));
                w = tb_flip(w, a);
                apply(odd, w[DW-1:0], w[DW+EW-1:DW], 1'b1, 1'b0, d,
                      (a != 0 && !tb_pow2(a)) ? "R3 random single" : "R4 random single");
            end else begin
                a = int'($urandom_range(NPOS, 0));
                b = int'($urandom_range(NPOS - 1, 0));
                if (b >= a) b++;
                w = tb_flip(tb_flip(w, a), b);
                apply(odd, w[DW-1:0], w[DW+EW-1:DW], 1'b0, 1'b1, w[DW-1:0], "R6 random double");
            end
        end
        // R8 is covered by every check above: expected flags are never both 1.
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule